// File: doc/BRIEF.md
# Pseudo-Associative Serial Lookup Cache

This block is a small read/write cache that gets set-associative behaviour out of a single direct-mapped storage array. The array holds `LINES` one-word lines. It is viewed as `WAYS` ways of `LINES/WAYS` sets each. A lookup does not compare all ways at once. It forms the line index by placing a probe number above the set bits of the address and reads one line per cycle, starting with probe 0. It stops at the first tag match, so a hit in a low way returns sooner than a hit in a high way.

When every probe misses, a read asks the backing memory for the word and installs it. A write allocates its line at once with the write data and does not fetch, because a line is one word wide. The line is placed in the lowest probe position that holds nothing valid. If all positions in the set are occupied, a per-set round-robin pointer picks the victim. A victim marked dirty is sent to memory in the same cycle that the miss is acted on. Only one request is in flight at a time, and the requester waits for `req_ready`.

Top module: `pac_cache`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid`, `mem_rd_req` and `mem_wr_valid` are 0, and every line is invalid, so the first access to any address misses.
- R2: The set is `addr[SET_W-1:0]` and the tag is the remaining upper address bits. Probe p reads line index `{p, set}`. A hit on probe p raises `rsp_valid` p+1 cycles after the accepting edge, with `rsp_hit`=1, `rsp_way`=p and the stored word on `rsp_rdata`.
- R3: Probes run in ascending order 0,1,..,WAYS-1, one per cycle. A later probe runs only if every earlier probe missed.
- R4: A read that misses on all probes pulses `mem_rd_req` for one cycle, WAYS cycles after acceptance, with `mem_rd_addr` equal to the request address. One cycle after `mem_rd_valid` it answers with `rsp_hit`=0 and the returned word.
- R5: A missing line is placed in the lowest-numbered probe position of its set that is invalid, and `rsp_way` reports that position.
- R6: When all positions of a set are valid, the victim is that set's round-robin pointer. The pointer starts at 0 and advances by one, wrapping, each time it is used. Each set has its own pointer.
- R7: A write hit replaces the stored word and marks the line dirty. `rsp_rdata` echoes the written word, and later reads return it.
- R8: A write that misses installs the word as a dirty line without any memory read, and responds WAYS cycles after acceptance with `rsp_hit`=0.
- R9: Evicting a valid dirty line pulses `mem_wr_valid` for one cycle with the victim's address `{tag, set}` and word. The pulse falls in the same cycle as the `mem_rd_req` pulse of a read miss, or as the `rsp_valid` of a write miss. Evicting a clean or invalid line writes nothing.
- R10: `req_ready` is 0 from the cycle after acceptance until the cycle `rsp_valid` is 1. A request presented while `req_ready` is 0 is ignored and produces no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Cache idle, request taken on this edge |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write word |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | Response came from a tag match |
| rsp_way | output | $clog2(WAYS) | Probe position that hit or was filled |
| rsp_rdata | output | DATA_W | Read word, or echoed write word |
| mem_rd_req | output | 1 | One-cycle memory read request |
| mem_rd_addr | output | ADDR_W | Memory read address |
| mem_rd_valid | input | 1 | Memory read data present |
| mem_rd_data | input | DATA_W | Memory read word |
| mem_wr_valid | output | 1 | One-cycle write-back of a dirty victim |
| mem_wr_addr | output | ADDR_W | Write-back address |
| mem_wr_data | output | DATA_W | Write-back word |

## Verification
The eviction of a dirty victim and the handling of the miss that caused it fall on the same edge. The write-back comes out together with the memory read request on a read miss, or together with the response on a write miss. The bench provokes both cases by filling one set completely, dirtying selected ways with write hits or write allocations, and then missing in that set until the round-robin pointer reaches the dirty way. A reference model predicts which victim each miss picks and what it must write back. When the write-back pulse is seen, it is compared in address and data against the model, and the bench checks that the read request or the response is present in that very cycle.

// File: rtl/pac_pkg.sv
package pac_pkg;

  typedef enum logic [1:0] {
    PAC_IDLE  = 2'd0,
    PAC_PROBE = 2'd1,
    PAC_FETCH = 2'd2
  } pac_state_e;

endpackage

// File: rtl/pac_array.sv
module pac_array #(
  parameter int LINES  = 64,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [$clog2(LINES)-1:0] rd_idx,
  output logic                     rd_vld,
  output logic                     rd_dirty,
  output logic [TAG_W-1:0]         rd_tag,
  output logic [DATA_W-1:0]        rd_data,
  input  logic                     wr_en,
  input  logic [$clog2(LINES)-1:0] wr_idx,
  input  logic                     wr_dirty,
  input  logic [TAG_W-1:0]         wr_tag,
  input  logic [DATA_W-1:0]        wr_data
);
  localparam int WORD_W = 1 + TAG_W + DATA_W;

  logic [WORD_W-1:0] ram_q [LINES];
  logic [WORD_W-1:0] rd_word_q;
  logic [LINES-1:0]  vld_q;
  logic              rd_vld_q;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) ram_q[wr_idx] <= {wr_dirty, wr_tag, wr_data};
    rd_word_q <= ram_q[rd_idx];
  end

  // valid bits kept in flops so reset can clear them
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q    <= '0;
      rd_vld_q <= 1'b0;
    end else begin
      if (wr_en) vld_q[wr_idx] <= 1'b1;
      rd_vld_q <= vld_q[rd_idx];
    end
  end

  assign rd_vld   = rd_vld_q;
  assign rd_dirty = rd_word_q[WORD_W-1];
  assign rd_tag   = rd_word_q[DATA_W +: TAG_W];
  assign rd_data  = rd_word_q[DATA_W-1:0];

endmodule

// File: rtl/pac_victim.sv
module pac_victim #(
  parameter int WAYS = 4,
  parameter int SETS = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [$clog2(SETS)-1:0] set_idx,
  input  logic [WAYS-1:0]         vmask,
  input  logic                    commit,
  output logic [$clog2(WAYS)-1:0] victim
);
  localparam int WAY_W = $clog2(WAYS);

  logic [WAY_W-1:0] rr_q [SETS];
  logic             all_valid;

  assign all_valid = &vmask;

  always_comb begin
    victim = rr_q[set_idx];
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vmask[w]) victim = WAY_W'(w);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else if (commit && all_valid) begin
      rr_q[set_idx] <= rr_q[set_idx] + WAY_W'(1);
    end
  end

  // R6
  rr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (commit && all_valid) |=> rr_q[$past(set_idx)] == $past(rr_q[set_idx]) + WAY_W'(1));

endmodule

// File: rtl/pac_seq.sv
module pac_seq import pac_pkg::*; #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int LINES  = 64,
  parameter int WAYS   = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              req_valid,
  output logic                              req_ready,
  input  logic                              req_we,
  input  logic [ADDR_W-1:0]                 req_addr,
  input  logic [DATA_W-1:0]                 req_wdata,
  output logic                              rsp_valid,
  output logic                              rsp_hit,
  output logic [$clog2(WAYS)-1:0]           rsp_way,
  output logic [DATA_W-1:0]                 rsp_rdata,
  output logic                              mem_rd_req,
  output logic [ADDR_W-1:0]                 mem_rd_addr,
  input  logic                              mem_rd_valid,
  input  logic [DATA_W-1:0]                 mem_rd_data,
  output logic                              mem_wr_valid,
  output logic [ADDR_W-1:0]                 mem_wr_addr,
  output logic [DATA_W-1:0]                 mem_wr_data,
  output logic [$clog2(LINES)-1:0]          rd_idx,
  input  logic                              rd_vld,
  input  logic                              rd_dirty,
  input  logic [ADDR_W-$clog2(LINES/WAYS)-1:0] rd_tag,
  input  logic [DATA_W-1:0]                 rd_data,
  output logic                              wr_en,
  output logic [$clog2(LINES)-1:0]          wr_idx,
  output logic                              wr_dirty,
  output logic [ADDR_W-$clog2(LINES/WAYS)-1:0] wr_tag,
  output logic [DATA_W-1:0]                 wr_data,
  output logic [$clog2(LINES/WAYS)-1:0]     vic_set,
  output logic [WAYS-1:0]                   vic_mask,
  output logic                              vic_commit,
  input  logic [$clog2(WAYS)-1:0]           vic_way
);
  localparam int SETS  = LINES / WAYS;
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - SET_W;

  pac_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;
  logic [WAY_W-1:0]  probe_q;
  logic [WAY_W-1:0]  probe_nx;
  logic [WAY_W-1:0]  fill_q;
  logic [WAYS-1:0]   vmask_q;
  logic [TAG_W-1:0]  ptag_q   [WAYS];
  logic              pdirty_q [WAYS];
  logic [DATA_W-1:0] pdata_q  [WAYS];

  logic [SET_W-1:0]  set_q;
  logic [TAG_W-1:0]  tag_q;
  logic              in_probe;
  logic              hit;
  logic              last;
  logic              accept;
  logic [WAYS-1:0]   vmask_now;
  logic [TAG_W-1:0]  v_tag;
  logic              v_dirty;
  logic [DATA_W-1:0] v_data;
  logic              v_wb;

  assign set_q     = addr_q[SET_W-1:0];
  assign tag_q     = addr_q[ADDR_W-1:SET_W];
  assign in_probe  = (state_q == PAC_PROBE);
  assign hit       = in_probe && rd_vld && (rd_tag == tag_q);
  assign last      = (probe_q == WAY_W'(WAYS - 1));
  assign probe_nx  = probe_q + WAY_W'(1);
  assign req_ready = (state_q == PAC_IDLE);
  assign accept    = req_valid && req_ready;

  // valid map of the set as seen through the current probe
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      vmask_now[w] = (WAY_W'(w) == probe_q) ? rd_vld : vmask_q[w];
    end
  end

  assign vic_set    = set_q;
  assign vic_mask   = vmask_now;
  assign vic_commit = in_probe && !hit && last;

  // victim contents: either the line just read or one captured earlier
  always_comb begin
    if (vic_way == probe_q) begin
      v_tag   = rd_tag;
      v_dirty = rd_dirty;
      v_data  = rd_data;
    end else begin
      v_tag   = ptag_q[vic_way];
      v_dirty = pdirty_q[vic_way];
      v_data  = pdata_q[vic_way];
    end
  end
  assign v_wb = vmask_now[vic_way] && v_dirty;

  // array read address: probe 0 on acceptance, next probe while searching
  always_comb begin
    if (state_q == PAC_IDLE) rd_idx = {WAY_W'(0), req_addr[SET_W-1:0]};
    else if (in_probe)       rd_idx = {probe_nx, set_q};
    else                     rd_idx = {WAY_W'(0), set_q};
  end

  // array write port
  always_comb begin
    wr_en    = 1'b0;
    wr_idx   = {probe_q, set_q};
    wr_dirty = 1'b1;
    wr_tag   = tag_q;
    wr_data  = wdata_q;
    if (hit && we_q) begin
      wr_en = 1'b1;
    end else if (vic_commit && we_q) begin
      wr_en  = 1'b1;
      wr_idx = {vic_way, set_q};
    end else if (state_q == PAC_FETCH && mem_rd_valid) begin
      wr_en    = 1'b1;
      wr_idx   = {fill_q, set_q};
      wr_dirty = 1'b0;
      wr_data  = mem_rd_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= PAC_IDLE;
      addr_q       <= '0;
      we_q         <= 1'b0;
      wdata_q      <= '0;
      probe_q      <= '0;
      fill_q       <= '0;
      vmask_q      <= '0;
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_way      <= '0;
      rsp_rdata    <= '0;
      mem_rd_req   <= 1'b0;
      mem_rd_addr  <= '0;
      mem_wr_valid <= 1'b0;
      mem_wr_addr  <= '0;
      mem_wr_data  <= '0;
      for (int w = 0; w < WAYS; w++) begin
        ptag_q[w]   <= '0;
        pdirty_q[w] <= 1'b0;
        pdata_q[w]  <= '0;
      end
    end else begin
      rsp_valid    <= 1'b0;
      mem_rd_req   <= 1'b0;
      mem_wr_valid <= 1'b0;
      unique case (state_q)
        PAC_IDLE: begin
          if (accept) begin
            addr_q  <= req_addr;
            we_q    <= req_we;
            wdata_q <= req_wdata;
            probe_q <= '0;
            vmask_q <= '0;
            state_q <= PAC_PROBE;
          end
        end
        PAC_PROBE: begin
          vmask_q[probe_q]  <= rd_vld;
          ptag_q[probe_q]   <= rd_tag;
          pdirty_q[probe_q] <= rd_dirty;
          pdata_q[probe_q]  <= rd_data;
          if (hit) begin
            rsp_valid <= 1'b1;
            rsp_hit   <= 1'b1;
            rsp_way   <= probe_q;
            rsp_rdata <= we_q ? wdata_q : rd_data;
            state_q   <= PAC_IDLE;
          end else if (last) begin
            if (v_wb) begin
              mem_wr_valid <= 1'b1;
              mem_wr_addr  <= {v_tag, set_q};
              mem_wr_data  <= v_data;
            end
            fill_q <= vic_way;
            if (we_q) begin
              rsp_valid <= 1'b1;
              rsp_hit   <= 1'b0;
              rsp_way   <= vic_way;
              rsp_rdata <= wdata_q;
              state_q   <= PAC_IDLE;
            end else begin
              mem_rd_req  <= 1'b1;
              mem_rd_addr <= addr_q;
              state_q     <= PAC_FETCH;
            end
          end else begin
            probe_q <= probe_nx;
          end
        end
        PAC_FETCH: begin
          if (mem_rd_valid) begin
            rsp_valid <= 1'b1;
            rsp_hit   <= 1'b0;
            rsp_way   <= fill_q;
            rsp_rdata <= mem_rd_data;
            state_q   <= PAC_IDLE;
          end
        end
        default: state_q <= PAC_IDLE;
      endcase
    end
  end

  // R3
  probe_step_chk: assert property (@(posedge clk) disable iff (rst)
    (in_probe && !hit && !last) |=> (in_probe && probe_q == $past(probe_q) + WAY_W'(1)));

  // R4
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |=> (!mem_rd_req && !rsp_valid));

  // R9
  wb_align_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid |-> (mem_rd_req || rsp_valid));

  // R10
  busy_gap_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (req_ready && $past(!req_ready)));

endmodule

// File: rtl/pac_cache.sv
module pac_cache #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int LINES  = 64,
  parameter int WAYS   = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_we,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    rsp_valid,
  output logic                    rsp_hit,
  output logic [$clog2(WAYS)-1:0] rsp_way,
  output logic [DATA_W-1:0]       rsp_rdata,
  output logic                    mem_rd_req,
  output logic [ADDR_W-1:0]       mem_rd_addr,
  input  logic                    mem_rd_valid,
  input  logic [DATA_W-1:0]       mem_rd_data,
  output logic                    mem_wr_valid,
  output logic [ADDR_W-1:0]       mem_wr_addr,
  output logic [DATA_W-1:0]       mem_wr_data
);
  localparam int SETS   = LINES / WAYS;
  localparam int SET_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int LINE_W = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - SET_W;

  logic [LINE_W-1:0] rd_idx;
  logic              rd_vld;
  logic              rd_dirty;
  logic [TAG_W-1:0]  rd_tag;
  logic [DATA_W-1:0] rd_data;
  logic              wr_en;
  logic [LINE_W-1:0] wr_idx;
  logic              wr_dirty;
  logic [TAG_W-1:0]  wr_tag;
  logic [DATA_W-1:0] wr_data;
  logic [SET_W-1:0]  vic_set;
  logic [WAYS-1:0]   vic_mask;
  logic              vic_commit;
  logic [WAY_W-1:0]  vic_way;

  pac_array #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst(rst),
    .rd_idx(rd_idx), .rd_vld(rd_vld), .rd_dirty(rd_dirty),
    .rd_tag(rd_tag), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_dirty(wr_dirty),
    .wr_tag(wr_tag), .wr_data(wr_data)
  );

  pac_victim #(.WAYS(WAYS), .SETS(SETS)) u_victim (
    .clk(clk), .rst(rst),
    .set_idx(vic_set), .vmask(vic_mask), .commit(vic_commit),
    .victim(vic_way)
  );

  pac_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WAYS(WAYS)) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
    .rsp_rdata(rsp_rdata),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data),
    .rd_idx(rd_idx), .rd_vld(rd_vld), .rd_dirty(rd_dirty),
    .rd_tag(rd_tag), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_dirty(wr_dirty),
    .wr_tag(wr_tag), .wr_data(wr_data),
    .vic_set(vic_set), .vic_mask(vic_mask), .vic_commit(vic_commit),
    .vic_way(vic_way)
  );

endmodule

// File: tb/pac_cache_bench.sv
module pac_cache_bench;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int LINES  = 64;
  localparam int WAYS   = 4;
  localparam int SETS   = LINES / WAYS;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_we = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              rsp_valid;
  logic              rsp_hit;
  logic [1:0]        rsp_way;
  logic [DATA_W-1:0] rsp_rdata;
  logic              mem_rd_req;
  logic [ADDR_W-1:0] mem_rd_addr;
  logic              mem_rd_valid = 1'b0;
  logic [DATA_W-1:0] mem_rd_data = '0;
  logic              mem_wr_valid;
  logic [ADDR_W-1:0] mem_wr_addr;
  logic [DATA_W-1:0] mem_wr_data;

  pac_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WAYS(WAYS)) u_pac_cache (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
    .rsp_rdata(rsp_rdata),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data)
  );

  always #4 clk = ~clk;  // 125 MHz

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int acc   = 0;
  int rd_cnt = 0;
  int exp_rd = 0;
  bit done  = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic        hit;
    logic [1:0]  way;
    logic [31:0] data;
    int          lat;
    string       rq;
  } rsp_item_t;

  typedef struct {
    logic [11:0] addr;
    logic [31:0] data;
  } wb_item_t;

  rsp_item_t rsp_q[$];
  wb_item_t  wb_q[$];

  // reference state
  logic        m_vld [LINES];
  logic        m_dty [LINES];
  logic [7:0]  m_tag [LINES];
  logic [31:0] m_dat [LINES];
  logic [1:0]  m_rr  [SETS];
  logic [31:0] bmem  [int];

  function automatic logic [31:0] bmem_get(input logic [11:0] a);
    if (bmem.exists(int'(a))) return bmem[int'(a)];
    return 32'hC0DE_0000 | {20'd0, a};
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // memory responder: fixed two-cycle turnaround
  int          pend = 0;
  logic [11:0] pend_addr = '0;
  always @(negedge clk) begin
    mem_rd_valid <= 1'b0;
    if (pend > 0) begin
      if (pend == 1) begin
        mem_rd_valid <= 1'b1;
        mem_rd_data  <= bmem_get(pend_addr);
      end
      pend <= pend - 1;
    end
    if (!rst && mem_rd_req) begin
      rd_cnt++;
      pend_addr <= mem_rd_addr;
      pend      <= 2;
    end
  end

  // write-back monitor
  always @(negedge clk) begin
    if (!rst && mem_wr_valid) begin
      if (wb_q.size() == 0) begin
        check(1'b0, "R9", "unexpected write-back addr", {20'd0, mem_wr_addr}, 32'h0);
      end else begin
        wb_item_t e;
        e = wb_q.pop_front();
        check(mem_wr_addr == e.addr, "R9", "write-back addr", {20'd0, mem_wr_addr}, {20'd0, e.addr});
        check(mem_wr_data == e.data, "R9", "write-back data", mem_wr_data, e.data);
        check(mem_rd_req || rsp_valid, "R9", "write-back not aligned with miss action",
              {31'd0, mem_rd_req || rsp_valid}, 32'd1);
      end
    end
  end

  // response monitor (scoreboard)
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (rsp_q.size() == 0) begin
        check(1'b0, "R10", "unexpected response data", rsp_rdata, 32'h0);
      end else begin
        rsp_item_t e;
        e = rsp_q.pop_front();
        check(rsp_hit == e.hit, e.rq, "rsp_hit", {31'd0, rsp_hit}, {31'd0, e.hit});
        check(rsp_way == e.way, e.rq, "rsp_way", {30'd0, rsp_way}, {30'd0, e.way});
        check(rsp_rdata == e.data, e.rq, "rsp_rdata", rsp_rdata, e.data);
        check(cyc - acc == e.lat, e.rq, "latency", cyc - acc, e.lat);
      end
    end
  end

  // predicts one access, updates the reference state, queues expectations
  task automatic predict(input logic we, input logic [11:0] a, input logic [31:0] wd,
                         input string rq);
    rsp_item_t it;
    int        set = int'(a[3:0]);
    logic [7:0] tag = a[11:4];
    bit        hit = 1'b0;
    int        way = 0;
    for (int p = 0; p < WAYS; p++) begin
      int ix = p * SETS + set;
      if (!hit && m_vld[ix] && m_tag[ix] == tag) begin
        hit = 1'b1;
        way = p;
      end
    end
    it.rq = rq;
    if (hit) begin
      int ix = way * SETS + set;
      if (we) begin
        m_dat[ix] = wd;
        m_dty[ix] = 1'b1;
      end
      it.hit = 1'b1; it.way = 2'(way); it.data = m_dat[ix]; it.lat = way + 1;
    end else begin
      bit full = 1'b1;
      int v = -1;
      int ix;
      for (int p = 0; p < WAYS; p++) begin
        if (!m_vld[p * SETS + set]) begin
          full = 1'b0;
          if (v < 0) v = p;
        end
      end
      if (full) begin
        v = int'(m_rr[set]);
        m_rr[set] = m_rr[set] + 2'd1;
      end
      ix = v * SETS + set;
      if (m_vld[ix] && m_dty[ix]) begin
        wb_item_t w;
        w.addr = {m_tag[ix], a[3:0]};
        w.data = m_dat[ix];
        wb_q.push_back(w);
        bmem[int'(w.addr)] = w.data;
      end
      m_vld[ix] = 1'b1;
      m_tag[ix] = tag;
      it.hit = 1'b0; it.way = 2'(v);
      if (we) begin
        m_dat[ix] = wd; m_dty[ix] = 1'b1;
        it.data = wd; it.lat = WAYS;
      end else begin
        m_dat[ix] = bmem_get(a); m_dty[ix] = 1'b0;
        it.data = m_dat[ix]; it.lat = WAYS + 3;
        exp_rd++;
      end
    end
    rsp_q.push_back(it);
  endtask

  // driver
  task automatic access(input logic we, input logic [11:0] a, input logic [31:0] wd,
                        input string rq, input bit junk = 1'b0);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    predict(we, a, wd, rq);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    acc = cyc;
    check(req_ready == 1'b0, "R10", "req_ready while busy", {31'd0, req_ready}, 32'd0);
    if (junk) begin
      req_we = 1'b1; req_addr = 12'hFF3; req_wdata = 32'hDEAD_BEEF;
      @(negedge clk);
    end
    req_valid = 1'b0;
    while (rsp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    check(rd_cnt == exp_rd, rq, "memory read count", rd_cnt, exp_rd);
    check(wb_q.size() == 0, rq, "pending write-backs", wb_q.size(), 0);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < LINES; i++) begin
      m_vld[i] = 1'b0; m_dty[i] = 1'b0; m_tag[i] = '0; m_dat[i] = '0;
    end
    for (int s = 0; s < SETS; s++) m_rr[s] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state while reset is held
    check(req_ready == 1'b1, "R1", "req_ready in reset", {31'd0, req_ready}, 32'd1);
    check(rsp_valid == 1'b0, "R1", "rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
    check(mem_rd_req == 1'b0, "R1", "mem_rd_req in reset", {31'd0, mem_rd_req}, 32'd0);
    check(mem_wr_valid == 1'b0, "R1", "mem_wr_valid in reset", {31'd0, mem_wr_valid}, 32'd0);
    rst = 1'b0;
    // R1 cold miss, R4 fetch, R5 lowest invalid position
    access(1'b0, 12'h013, 32'h0, "R4");
    // R2 probe-0 hit
    access(1'b0, 12'h013, 32'h0, "R2");
    // R5 fill ways 1..3 in order
    access(1'b0, 12'h023, 32'h0, "R5");
    access(1'b0, 12'h033, 32'h0, "R5");
    access(1'b0, 12'h043, 32'h0, "R5");
    // R3 deeper hits take more cycles
    access(1'b0, 12'h043, 32'h0, "R3");
    access(1'b0, 12'h033, 32'h0, "R3");
    access(1'b0, 12'h023, 32'h0, "R3");
    // R7 write hit then read back
    access(1'b1, 12'h023, 32'hA5A5_0023, "R7");
    access(1'b0, 12'h023, 32'h0, "R7");
    // R6 full set: pointer 0 evicts clean way 0
    access(1'b0, 12'h053, 32'h0, "R6");
    // R9 pointer 1 evicts dirty way 1 alongside the read request
    access(1'b0, 12'h063, 32'h0, "R9");
    // R8 write miss, no fetch, clean victim way 2
    access(1'b1, 12'h073, 32'h1111_0073, "R8");
    access(1'b1, 12'h083, 32'h1111_0083, "R8");
    access(1'b0, 12'h093, 32'h0, "R6");
    access(1'b0, 12'h0A3, 32'h0, "R6");
    // R9 write miss evicting dirty way 2 alongside the response
    access(1'b1, 12'h0B3, 32'h2222_00B3, "R9");
    // R6 another set keeps its own pointer
    access(1'b0, 12'h105, 32'h0, "R5");
    access(1'b0, 12'h115, 32'h0, "R5");
    access(1'b1, 12'h125, 32'h3333_0125, "R8");
    access(1'b0, 12'h135, 32'h0, "R5");
    access(1'b0, 12'h145, 32'h0, "R6");
    // evicted line comes back from memory with its written-back value
    access(1'b0, 12'h023, 32'h0, "R9");
    // R10 request held during busy cycles is ignored
    access(1'b0, 12'h145, 32'h0, "R10", 1'b1);
    repeat (8) @(negedge clk);
    check(rsp_q.size() == 0, "R10", "queued responses after ignored request", rsp_q.size(), 0);
    access(1'b0, 12'hFF3, 32'h0, "R10");
    done = 1'b1;
    finish_run();
  end

endmodule